// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block is a 1 KB, two-way set-associative data cache with 32-byte lines, placed between a processor's word load/store port and a simple word-wide memory port. Loads that hit are answered in the cycle they are presented. A load that misses fetches the whole line from memory and then completes.

Stores use a write-through policy. Every store goes into a four-entry FIFO write buffer, which drains to memory one word at a time. A store that hits also updates the cached word. A store that misses leaves the cache contents unchanged. The processor stalls on a store only when the buffer is full.

A load miss first waits for the buffer to empty, so the line it fetches already holds every earlier store. No dirty data ever exists, so a refill never writes a victim line back to memory. Replacement inside a set follows one least-recently-used bit per set.

Top module: `cache_wt2`

## Requirements
- R1: After reset every line is invalid, the write buffer is empty, `mem_req_o` is low and `cpu_ready_o` is low. The first load to any address therefore refills its line from memory.
- R2: The address is split into byte offset `[4:0]` (word select `[4:2]`), set index `[8:5]` (16 sets) and tag `[31:9]`. A load anywhere in a line refills from the line base, whose bits `[4:0]` are zero.
- R3: A load that hits raises `cpu_ready_o` in the same cycle as `cpu_req_i`, with the addressed word on `cpu_rdata_o`, and causes no memory traffic.
- R4: Both ways of the indexed set are compared with the address tag in parallel, and data is taken from the way that matched. Two lines with the same index and different tags are both resident, and at most one way matches.
- R5: Each set has one LRU bit that points at the way to replace, and it is set to the other way on every hit and every refill. A miss fills an invalid way first (way 0 before way 1). When both ways are valid, the miss replaces the way the bit points at.
- R6: A load miss waits until the write buffer is empty. It then issues eight memory reads in ascending word order from the line base, writes them into the victim way, and completes with the requested word.
- R7: A store raises `cpu_ready_o` in its request cycle when the buffer is not full. If it hits, the cached word is overwritten. The store always produces one memory write with the same address and data.
- R8: A store miss does not allocate a line, so a later load to that line misses and refills.
- R9: The write buffer holds four stores and writes them to memory in issue order. A store presented while it is full is stalled, with `cpu_ready_o` low, until an entry drains.
- R10: Memory writes come only from the write buffer. A refill never issues a memory write.
- R11: `mem_req_o` stays high, with address, direction and (for writes) data stable, until `mem_ack_i`. One `mem_ack_i` cycle completes one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Access request, held until `cpu_ready_o` |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address (word aligned) |
| cpu_wdata_i | input | 32 | Store data |
| cpu_ready_o | output | 1 | Access completes in this cycle |
| cpu_rdata_o | output | 32 | Load data, valid with `cpu_ready_o` on a load |
| mem_req_o | output | 1 | Memory word request, held until acknowledged |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory completes the current word |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ack_i` |

## Verification
The check depends on when each result is due. A load hit and a store with room in the buffer are due in the request cycle itself. The bench drives each request at a falling edge and samples `cpu_ready_o` one nanosecond later, so a latency count of exactly one cycle is demanded for these cases. Load misses and stores to a full buffer finish after a variable number of cycles, set by the memory model's latency. The bench never predicts that number. It checks that it exceeds one cycle, and it checks the memory transactions recorded at each acknowledge for count, order, address and data. Load data is compared by a scoreboard against a shadow memory that is updated in program order when each store is issued.

// File: rtl/cache_wt2_pkg.sv
package cache_wt2_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/cache_wbuf.sv
module cache_wbuf
  import cache_wt2_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  wb_entry_t push_data_i,
  input  logic      pop_i,
  output wb_entry_t head_o,
  output logic      empty_o,
  output logic      full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wb_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= ptr_inc(wr_q);
      if (pop_ok)  rd_q <= ptr_inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/cache_way.sv
module cache_way
  import cache_wt2_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 8
) (
  input  logic                                           clk_i,
  input  logic                                           rst_ni,
  input  logic [$clog2(SETS)-1:0]                        lk_idx_i,
  input  logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-3:0] lk_tag_i,
  input  logic [$clog2(LINE_WORDS)-1:0]                  lk_woff_i,
  output logic                                           match_o,
  output logic                                           valid_o,
  output logic [DATA_W-1:0]                              rdata_o,
  input  logic                                           wr_en_i,
  input  logic [$clog2(SETS)-1:0]                        wr_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0]                  wr_woff_i,
  input  logic [DATA_W-1:0]                              wr_data_i,
  input  logic                                           fill_done_i,
  input  logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-3:0] fill_tag_i
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - 2;

  logic [DATA_W-1:0] data_q [SETS][LINE_WORDS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [SETS-1:0]   valid_q;

  assign valid_o = valid_q[lk_idx_i];
  assign match_o = valid_o && (tag_q[lk_idx_i] == lk_tag_i);
  assign rdata_o = data_q[lk_idx_i][lk_woff_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i)     data_q[wr_idx_i][wr_woff_i] <= wr_data_i;
    if (fill_done_i) tag_q[wr_idx_i] <= fill_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          valid_q <= '0;
    else if (fill_done_i) valid_q[wr_idx_i] <= 1'b1;
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(SETS)-1:0] rd_idx_i,
  output logic                    repl_way_o,
  input  logic                    upd_i,
  input  logic [$clog2(SETS)-1:0] upd_idx_i,
  input  logic                    used_way_i
);
  logic [SETS-1:0] bits_q;

  assign repl_way_o = bits_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bits_q <= '0;
    else if (upd_i) bits_q[upd_idx_i] <= ~used_way_i;
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_wt2_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  parameter int BLK_W      = 27
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [BLK_W-1:0]              blk_addr_i,
  input  logic                          hit_i,
  input  logic                          hit_way_i,
  input  logic [1:0]                    valid_i,
  input  logic                          lru_way_i,
  input  logic                          wb_full_i,
  input  logic                          wb_empty_i,
  input  logic                          mem_ack_i,
  output logic                          ready_o,
  output logic                          wb_push_o,
  output logic                          st_wr_o,
  output logic                          fill_busy_o,
  output logic                          fill_wr_o,
  output logic                          fill_done_o,
  output logic                          fill_way_o,
  output logic [$clog2(LINE_WORDS)-1:0] fill_woff_o,
  output logic [BLK_W-1:0]              miss_blk_o,
  output logic                          lru_upd_o,
  output logic                          lru_used_o
);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(LINE_WORDS - 1);

  ctl_state_e        state_q, state_d;
  logic [WOFF_W-1:0] cnt_q;
  logic [BLK_W-1:0]  miss_blk_q;
  logic              fill_way_q, victim, miss_ld;

  // invalid way first, then LRU
  assign victim = !valid_i[0] ? 1'b0 : (!valid_i[1] ? 1'b1 : lru_way_i);

  always_comb begin
    state_d    = state_q;
    ready_o    = 1'b0;
    wb_push_o  = 1'b0;
    st_wr_o    = 1'b0;
    lru_upd_o  = 1'b0;
    lru_used_o = hit_way_i;
    miss_ld    = 1'b0;
    fill_wr_o  = 1'b0;
    fill_done_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (we_i) begin
            if (!wb_full_i) begin
              ready_o   = 1'b1;
              wb_push_o = 1'b1;
              st_wr_o   = hit_i;
              lru_upd_o = hit_i;
            end
          end else if (hit_i) begin
            ready_o   = 1'b1;
            lru_upd_o = 1'b1;
          end else begin
            miss_ld = 1'b1;
            state_d = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (wb_empty_i) state_d = ST_FILL;
      end
      ST_FILL: begin
        if (mem_ack_i) begin
          fill_wr_o = 1'b1;
          if (cnt_q == LAST_WORD) begin
            fill_done_o = 1'b1;
            lru_upd_o   = 1'b1;
            lru_used_o  = fill_way_q;
            state_d     = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign fill_busy_o = (state_q == ST_FILL);
  assign fill_way_o  = fill_way_q;
  assign fill_woff_o = cnt_q;
  assign miss_blk_o  = miss_blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      miss_blk_q <= '0;
      fill_way_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (miss_ld) begin
        miss_blk_q <= blk_addr_i;
        fill_way_q <= victim;
      end
      if (state_q == ST_DRAIN) cnt_q <= '0;
      else if (fill_wr_o)      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cache_wt2.sv
module cache_wt2
  import cache_wt2_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 8,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int WAYS   = 2;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = WOFF_W + 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;

  logic [IDX_W-1:0]  lk_idx, miss_idx, wr_idx;
  logic [TAG_W-1:0]  lk_tag, miss_tag;
  logic [WOFF_W-1:0] lk_woff, fill_woff, wr_woff;
  logic [BLK_W-1:0]  miss_blk;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rdata_arr [WAYS];
  logic [WAYS-1:0]   hit_vec, valid_vec;
  logic              hit, hit_way, repl_way;
  logic              wb_push, wb_pop, wb_full, wb_empty;
  logic              st_wr, fill_busy, fill_wr, fill_done, fill_way;
  logic              lru_upd, lru_used;
  wb_entry_t         wb_in, wb_head;
  logic [1:0]        unused_lo;

  assign unused_lo = cpu_addr_i[1:0];

  assign lk_idx   = cpu_addr_i[OFF_W +: IDX_W];
  assign lk_tag   = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign lk_woff  = cpu_addr_i[2 +: WOFF_W];
  assign miss_idx = miss_blk[IDX_W-1:0];
  assign miss_tag = miss_blk[BLK_W-1 -: TAG_W];

  // refill beats win the line write port; the CPU is stalled then
  assign wr_idx  = fill_wr ? miss_idx    : lk_idx;
  assign wr_woff = fill_wr ? fill_woff   : lk_woff;
  assign wr_data = fill_wr ? mem_rdata_i : cpu_wdata_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_en_w, done_w;
    assign wr_en_w = (st_wr && (hit_way == 1'(w))) || (fill_wr && (fill_way == 1'(w)));
    assign done_w  = fill_done && (fill_way == 1'(w));
    cache_way #(
      .SETS       (SETS),
      .LINE_WORDS (LINE_WORDS)
    ) u_way (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lk_idx_i    (lk_idx),
      .lk_tag_i    (lk_tag),
      .lk_woff_i   (lk_woff),
      .match_o     (hit_vec[w]),
      .valid_o     (valid_vec[w]),
      .rdata_o     (rdata_arr[w]),
      .wr_en_i     (wr_en_w),
      .wr_idx_i    (wr_idx),
      .wr_woff_i   (wr_woff),
      .wr_data_i   (wr_data),
      .fill_done_i (done_w),
      .fill_tag_i  (miss_tag)
    );
  end

  assign hit         = |hit_vec;
  assign hit_way     = hit_vec[1];
  assign cpu_rdata_o = rdata_arr[hit_way];

  cache_lru #(.SETS(SETS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_idx),
    .repl_way_o (repl_way),
    .upd_i      (lru_upd),
    .upd_idx_i  (fill_done ? miss_idx : lk_idx),
    .used_way_i (lru_used)
  );

  assign wb_in.addr = cpu_addr_i;
  assign wb_in.data = cpu_wdata_i;
  assign wb_pop     = mem_ack_i && !fill_busy;

  cache_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wb_push),
    .push_data_i (wb_in),
    .pop_i       (wb_pop),
    .head_o      (wb_head),
    .empty_o     (wb_empty),
    .full_o      (wb_full)
  );

  cache_ctrl #(
    .LINE_WORDS (LINE_WORDS),
    .BLK_W      (BLK_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (cpu_req_i),
    .we_i        (cpu_we_i),
    .blk_addr_i  (cpu_addr_i[ADDR_W-1:OFF_W]),
    .hit_i       (hit),
    .hit_way_i   (hit_way),
    .valid_i     (valid_vec),
    .lru_way_i   (repl_way),
    .wb_full_i   (wb_full),
    .wb_empty_i  (wb_empty),
    .mem_ack_i   (mem_ack_i),
    .ready_o     (cpu_ready_o),
    .wb_push_o   (wb_push),
    .st_wr_o     (st_wr),
    .fill_busy_o (fill_busy),
    .fill_wr_o   (fill_wr),
    .fill_done_o (fill_done),
    .fill_way_o  (fill_way),
    .fill_woff_o (fill_woff),
    .miss_blk_o  (miss_blk),
    .lru_upd_o   (lru_upd),
    .lru_used_o  (lru_used)
  );

  // one memory port: refill reads, otherwise buffer drain
  assign mem_req_o   = fill_busy || !wb_empty;
  assign mem_we_o    = !fill_busy;
  assign mem_addr_o  = fill_busy ? {miss_blk, fill_woff, 2'b00} : wb_head.addr;
  assign mem_wdata_o = wb_head.data;
endmodule

// File: rtl/cache_wt2_chk.sv
module cache_wt2_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_req_i,
  input logic        cpu_we_i,
  input logic        cpu_ready_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic [1:0]  hit_vec,
  input logic        wb_full,
  input logic        wb_empty
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!mem_req_o && !cpu_ready_o);
    end
  end

  p_ready_has_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  p_single_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_fill_after_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> wb_empty);

  p_full_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && wb_full) |-> !cpu_ready_o);

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && (!mem_we_o || $stable(mem_wdata_o))));
endmodule

bind cache_wt2 cache_wt2_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_ready_o (cpu_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .hit_vec     (hit_vec),
  .wb_full     (wb_full),
  .wb_empty    (wb_empty)
);

// File: tb/sim_cache_wt2.sv
module sim_cache_wt2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready_o;
  logic [31:0] cpu_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  cache_wt2 u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem    [1024];
  logic [31:0] shadow [1024];
  int          lat_cfg = 1;
  bit          busy = 1'b0;
  int          wait_cnt = 0;
  logic [31:0] cap_addr = '0, cap_data = '0;
  bit          cap_we = 1'b0;
  int          stab_err = 0;
  bit          lg_we   [$];
  logic [31:0] lg_addr [$];
  logic [31:0] lg_data [$];

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 32'h5A000000 ^ (i * 32'h00010003);
      shadow[i] = 32'h5A000000 ^ (i * 32'h00010003);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      busy    <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      busy    <= 1'b0;
    end else if (busy) begin
      if (mem_addr_o !== cap_addr || mem_we_o !== cap_we || !mem_req_o ||
          (cap_we && mem_wdata_o !== cap_data)) stab_err++;
      if (wait_cnt == 0) begin
        mem_ack <= 1'b1;
        lg_we.push_back(cap_we);
        lg_addr.push_back(cap_addr);
        if (cap_we) begin
          mem[cap_addr[11:2]] <= cap_data;
          lg_data.push_back(cap_data);
        end else begin
          mem_rdata <= mem[cap_addr[11:2]];
          lg_data.push_back(mem[cap_addr[11:2]]);
        end
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end else if (mem_req_o) begin
      busy     <= 1'b1;
      cap_addr <= mem_addr_o;
      cap_we   <= mem_we_o;
      cap_data <= mem_wdata_o;
      wait_cnt <= lat_cfg;
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] exp_q  [$];
  string       exp_rq [$];

  always @(negedge clk) begin
    #1;
    if (rst_n && cpu_req && cpu_ready_o && !cpu_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "load completed with nothing expected", cpu_rdata_o, '0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string r = exp_rq.pop_front();
        check(cpu_rdata_o === e, r, $sformatf("load data @%h", cpu_addr), cpu_rdata_o, e);
      end
    end
  end

  // driver: lat = cycles from request to completion (1 = same cycle)
  task automatic op(input bit we, input logic [31:0] a, input logic [31:0] d,
                    input string rq, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (!we) begin
      exp_q.push_back(shadow[a[11:2]]);
      exp_rq.push_back(rq);
    end else begin
      shadow[a[11:2]] = d;
    end
    lat = 0;
    forever begin
      #1;
      lat++;
      if (cpu_ready_o) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 5000 && q < 3; i++) begin
      @(negedge clk);
      if (!mem_req_o && !mem_ack) q++; else q = 0;
    end
  endtask

  function automatic int n_rd(input int from);
    int n = 0;
    for (int i = from; i < lg_we.size(); i++) if (!lg_we[i]) n++;
    return n;
  endfunction

  function automatic int n_wr(input int from);
    int n = 0;
    for (int i = from; i < lg_we.size(); i++) if (lg_we[i]) n++;
    return n;
  endfunction

  function automatic bit fill_seq(input int from, input logic [31:0] base);
    for (int k = 0; k < 8; k++) begin
      if (from + k >= lg_we.size()) return 1'b0;
      if (lg_we[from+k] || lg_addr[from+k] !== base + 32'(4 * k)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", '0, '0);
      summary();
      $finish;
    end
  end

  initial begin
    int lat, b;
    int sl [5];
    logic [31:0] sa [5];
    logic [31:0] sd [5];
    bit ok;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_req_o, "R1", "mem_req_o in reset", 32'(mem_req_o), 0);
    check(!cpu_ready_o, "R1", "cpu_ready_o in reset", 32'(cpu_ready_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req_o, "R1", "mem_req_o after reset", 32'(mem_req_o), 0);

    // cold miss
    b = lg_we.size();
    op(1'b0, 32'h000, '0, "R6", lat);
    check(n_rd(b) == 8, "R1", "cold load refill reads", n_rd(b), 8);
    check(fill_seq(b, 32'h000), "R6", "refill order from base", lg_addr[b], 32'h000);
    check(n_wr(b) == 0, "R10", "writes during refill", n_wr(b), 0);
    check(lat > 1, "R6", "miss latency", lat, 2);

    // hit in same line
    b = lg_we.size();
    op(1'b0, 32'h004, '0, "R3", lat);
    check(lat == 1, "R3", "hit latency", lat, 1);
    check(lg_we.size() == b, "R3", "memory traffic on hit", lg_we.size() - b, 0);

    // address split: index 3, word 5
    b = lg_we.size();
    op(1'b0, 32'h074, '0, "R2", lat);
    check(fill_seq(b, 32'h060), "R2", "refill base for 0x074", lg_addr[b], 32'h060);
    op(1'b0, 32'h074, '0, "R2", lat);
    check(lat == 1, "R2", "second access to 0x074 hits", lat, 1);

    // store hit
    b = lg_we.size();
    op(1'b1, 32'h008, 32'hDEADBEEF, "R7", lat);
    check(lat == 1, "R7", "store latency with room", lat, 1);
    wait_quiet();
    ok = (lg_we.size() == b + 1) && lg_we[b] && lg_addr[b] == 32'h008 && lg_data[b] == 32'hDEADBEEF;
    check(ok, "R7", "store written through", (lg_we.size() > b) ? lg_data[b] : '0, 32'hDEADBEEF);
    op(1'b0, 32'h008, '0, "R7", lat);
    check(lat == 1, "R7", "load after store hit latency", lat, 1);

    // store miss, no allocate
    op(1'b1, 32'h800, 32'h12345678, "R8", lat);
    wait_quiet();
    b = lg_we.size();
    op(1'b0, 32'h800, '0, "R8", lat);
    check(n_rd(b) == 8, "R8", "load after store miss refills", n_rd(b), 8);

    // two ways and LRU in set 5
    op(1'b0, 32'h0A0, '0, "R4", lat);
    op(1'b0, 32'h2A0, '0, "R4", lat);
    b = lg_we.size();
    op(1'b0, 32'h0A4, '0, "R4", lat);
    check(lat == 1, "R4", "way A resident", lat, 1);
    op(1'b0, 32'h2A4, '0, "R4", lat);
    check(lat == 1, "R4", "way B resident", lat, 1);
    check(lg_we.size() == b, "R4", "traffic for resident pair", lg_we.size() - b, 0);
    op(1'b0, 32'h0A8, '0, "R5", lat);
    b = lg_we.size();
    op(1'b0, 32'h4A0, '0, "R5", lat);
    check(n_rd(b) == 8 && n_wr(b) == 0, "R10", "eviction without write", n_wr(b), 0);
    op(1'b0, 32'h0AC, '0, "R5", lat);
    check(lat == 1, "R5", "recently used line kept", lat, 1);
    b = lg_we.size();
    op(1'b0, 32'h2A8, '0, "R5", lat);
    check(n_rd(b) == 8, "R5", "LRU line was replaced", n_rd(b), 8);

    // buffer full, ordering, drain before refill
    lat_cfg = 30;
    wait_quiet();
    b = lg_we.size();
    for (int i = 0; i < 5; i++) begin
      sa[i] = 32'h140 + 32'(4 * i);
      sd[i] = 32'hA0000000 + 32'(i * 17);
      op(1'b1, sa[i], sd[i], "R9", sl[i]);
    end
    for (int i = 0; i < 4; i++)
      check(sl[i] == 1, "R9", $sformatf("store %0d accepted at once", i), sl[i], 1);
    check(sl[4] > 1, "R9", "fifth store stalls", sl[4], 2);
    op(1'b0, 32'h340, '0, "R6", lat);
    ok = (lg_we.size() >= b + 13);
    for (int i = 0; i < 5; i++)
      if (ok && !(lg_we[b+i] && lg_addr[b+i] == sa[i] && lg_data[b+i] == sd[i])) ok = 1'b0;
    check(ok, "R9", "write order", lg_we.size() - b, 13);
    check(fill_seq(b + 5, 32'h340), "R6", "refill after drain", lg_we.size() - b, 13);
    check(n_wr(b) == 5, "R10", "only buffered writes", n_wr(b), 5);
    lat_cfg = 1;
    wait_quiet();

    check(stab_err == 0, "R11", "request stable until ack", stab_err, 0);
    check(exp_q.size() == 0, "R3", "loads outstanding", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule